// File: doc/BRIEF.md
# Dual-Host Bridge Command Register Block

This block holds the control words through which two hosts, joined by a bridge, set up their shared resources. Each host has its own config region of 32-bit words. The host reaches it through a simple word-addressed write port and a combinational read port.

A host stages an argument, a 64-bit target address and a length. It then writes an opcode to the command word. The block runs the command in the next cycle, clears the command word and posts a success or error code in the status word. The results are kept as register outputs:

- A doorbell count and an MSI/MSI-X select.
- A target address, a length and a valid flag for each memory window.

The same region holds fixed descriptor words. Each host reads these to learn the layout of the bridge: its topology role, the window count, where window 1 begins after the doorbell slots, where the scratchpad begins after the config region, the scratchpad count, and the doorbell slot size. A link command from each host sets or withdraws that host's binding request. When both hosts are bound, one event pulse goes to both hosts at the same time.

Top module: `dual_host_cmd_regs`

## Requirements
- R1: Word map, identical for both hosts except for topology:

  | Word | Contents |
  |---|---|
  | 0 | command (read/write) |
  | 1 | argument (read/write) |
  | 2 | status (read only) |
  | 3 | topology: 1 on host 0 (upstream), 2 on host 1 (downstream) |
  | 4 | address low (read/write) |
  | 5 | address high (read/write) |
  | 6 | size (read/write) |
  | 7 | window count: 4 |
  | 8 | window-1 byte offset: 128 |
  | 9 | scratchpad byte offset: 176 |
  | 10 | scratchpad count: 8 |
  | 11 | doorbell slot size: 4 bytes |
  | 12 to 43 | doorbell data |
  | any other | reads 0 |

- R2: A nonzero write to word 0 while no command is pending starts a command. In the cycle after that write, status reads 0. One cycle later, word 0 reads 0 and status reads 1 (success) or 2 (error).
- R3: Opcode 1 with argument[15:0] at most 32 sets the doorbell count to argument[15:0] and the MSI-X select to argument[16]. Doorbell data word 12+i then reads i+1 for i below the count, and 0 otherwise.
- R4: Opcode 2 with an argument below 4 stores {word 5, word 4} as the address of that window, stores word 6 as its size, and marks the window valid.
- R5: An opcode other than 1, 2 or 3, a window index of 4 or more, or a doorbell count above 32 gives status 2 and leaves every stored setting unchanged.
- R6: Opcode 3 with argument bit 0 set records a binding request for that host. The first cycle in which both requests are present is followed, one cycle later, by a single-cycle link event on both host outputs together.
- R7: Opcode 3 with argument bit 0 clear withdraws the request. While both requests stay present, no further event occurs. After a withdrawal, the next time both requests are present gives a new event.
- R8: Writes to words 2, 3 and 7 to 43, and a write of zero to word 0, change nothing that can be read.
- R9: After reset, every stored word, setting, request and event is 0.
- R10: Commands and register writes from one host never change the other host's words or settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 2 | Write strobe, one bit per host |
| bus_addr | input | 2x6 | Word index, one per host |
| bus_wdata | input | 2x32 | Write data, one per host |
| bus_rdata | output | 2x32 | Read data of the addressed word, one per host |
| link_up_evt | output | 2 | Link-up event pulse, one per host |
| db_count | output | 2x6 | Configured doorbell count per host |
| db_msix | output | 2 | MSI-X (1) or MSI (0) select per host |
| mw_valid | output | 2x4 | Window configured flags per host |
| mw_addr | output | 2x4x64 | Window target addresses per host |
| mw_size | output | 2x4x32 | Window lengths per host |

## Verification
The bench targets the following edges and the faults each one exposes:

- Doorbell count boundary: counts of 32 and 33. Getting the limit wrong either rejects a full set of doorbells or accepts a set too large.
- Window index boundary: index 3 and index 4. An off-by-one here writes a window that does not exist or refuses the last one.
- Error path: settings must stay frozen after a rejected command. A design that latched before checking would change them.
- Link join: one host binds first, then the other, then a host binds again, then a host withdraws and binds once more. A design that did not wait for both hosts would pulse early. One that did not detect the edge would pulse again on a repeated request. One that did not re-arm would stay silent after the withdrawal.

// File: rtl/hbr_pkg.sv
// Package: word indices, opcodes and status codes shared by the register block.
package hbr_pkg;
    localparam logic [31:0] W_CMD     = 32'd0;
    localparam logic [31:0] W_ARG     = 32'd1;
    localparam logic [31:0] W_STATUS  = 32'd2;
    localparam logic [31:0] W_TOPO    = 32'd3;
    localparam logic [31:0] W_ADDR_LO = 32'd4;
    localparam logic [31:0] W_ADDR_HI = 32'd5;
    localparam logic [31:0] W_SIZE    = 32'd6;
    localparam logic [31:0] W_MW_CNT  = 32'd7;
    localparam logic [31:0] W_MW1_OFS = 32'd8;
    localparam logic [31:0] W_SP_OFS  = 32'd9;
    localparam logic [31:0] W_SP_CNT  = 32'd10;
    localparam logic [31:0] W_DB_SZ   = 32'd11;
    localparam logic [31:0] W_DB_BASE = 32'd12;

    localparam logic [31:0] OP_DOORBELL = 32'd1;
    localparam logic [31:0] OP_WINDOW   = 32'd2;
    localparam logic [31:0] OP_LINK     = 32'd3;

    localparam logic [31:0] TOPO_UP   = 32'd1;
    localparam logic [31:0] TOPO_DOWN = 32'd2;

    typedef enum logic [1:0] {
        ST_NONE = 2'd0,
        ST_OK   = 2'd1,
        ST_ERR  = 2'd2
    } cmd_status_e;
endpackage

// File: rtl/hbr_host_port.sv
// Module: one host's config region.
// Holds the writable words, runs one command in the cycle after it is
// written, and keeps the doorbell and window settings that commands produce.
// Assumes one access per cycle and NUM_MW >= 2.
module hbr_host_port
    import hbr_pkg::*;
#(
    parameter int          NUM_MW         = 4,
    parameter int          DB_MAX         = 32,
    parameter int          DB_ENTRY_BYTES = 4,
    parameter int          SPAD_COUNT     = 8,
    parameter int          AW             = 6,
    parameter int          DBW            = 6,
    parameter logic [31:0] TOPO           = 32'd1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [AW-1:0]               addr,
    input  logic [31:0]                 wdata,
    output logic [31:0]                 rdata,
    output logic                        busy,
    output logic                        link_req,
    output logic [DBW-1:0]              db_count,
    output logic                        db_msix,
    output logic [NUM_MW-1:0]           mw_valid,
    output logic [NUM_MW-1:0][63:0]     mw_addr,
    output logic [NUM_MW-1:0][31:0]     mw_size
);
    localparam int          IDXW      = $clog2(NUM_MW);
    localparam logic [31:0] MW1_OFS   = 32'(DB_MAX * DB_ENTRY_BYTES);
    localparam logic [31:0] SP_OFS    = 32'((12 + DB_MAX) * 4);
    localparam logic [31:0] DB_END    = W_DB_BASE + 32'(DB_MAX);

    logic [31:0]  cmd_q, arg_q, alo_q, ahi_q, size_q;
    cmd_status_e  status_q, result;
    logic         do_db, do_mw, do_link;
    logic [31:0]  widx, db_entry;

    assign widx = 32'(addr);
    assign busy = (cmd_q != 32'd0);

    // Decode the pending command and judge whether its arguments are legal.
    always_comb begin
        result  = ST_ERR;
        do_db   = 1'b0;
        do_mw   = 1'b0;
        do_link = 1'b0;
        case (cmd_q)
            OP_DOORBELL: if (arg_q[15:0] <= 16'(DB_MAX)) begin
                result = ST_OK;
                do_db  = 1'b1;
            end
            OP_WINDOW: if (arg_q < 32'(NUM_MW)) begin
                result = ST_OK;
                do_mw  = 1'b1;
            end
            OP_LINK: begin
                result  = ST_OK;
                do_link = 1'b1;
            end
            default: result = ST_ERR;
        endcase
    end

    // Accept a command, run it the next cycle, and record its status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            status_q <= ST_NONE;
        end else if (busy) begin
            cmd_q    <= '0;
            status_q <= result;
        end else if (wr && widx == W_CMD && wdata != 32'd0) begin
            cmd_q    <= wdata;
            status_q <= ST_NONE;
        end
    end

    // Store the writable staging words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q  <= '0;
            alo_q  <= '0;
            ahi_q  <= '0;
            size_q <= '0;
        end else if (wr) begin
            if (widx == W_ARG)     arg_q  <= wdata;
            if (widx == W_ADDR_LO) alo_q  <= wdata;
            if (widx == W_ADDR_HI) ahi_q  <= wdata;
            if (widx == W_SIZE)    size_q <= wdata;
        end
    end

    // Latch doorbell settings and the binding request on success.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_count <= '0;
            db_msix  <= 1'b0;
            link_req <= 1'b0;
        end else begin
            if (busy && do_db) begin
                db_count <= DBW'(arg_q[15:0]);
                db_msix  <= arg_q[16];
            end
            if (busy && do_link) link_req <= arg_q[0];
        end
    end

    // One settings slot per memory window.
    for (genvar w = 0; w < NUM_MW; w++) begin : g_win
        // Capture target and length when this window is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mw_valid[w] <= 1'b0;
                mw_addr[w]  <= '0;
                mw_size[w]  <= '0;
            end else if (busy && do_mw && arg_q[IDXW-1:0] == IDXW'(w)) begin
                mw_valid[w] <= 1'b1;
                mw_addr[w]  <= {ahi_q, alo_q};
                mw_size[w]  <= size_q;
            end
        end
    end

    // Value of the doorbell data word currently addressed.
    always_comb begin
        db_entry = widx - W_DB_BASE;
        if (db_entry < 32'(db_count)) db_entry = db_entry + 32'd1;
        else                          db_entry = 32'd0;
    end

    // Read multiplexer over the config region.
    always_comb begin
        case (widx)
            W_CMD:     rdata = cmd_q;
            W_ARG:     rdata = arg_q;
            W_STATUS:  rdata = 32'(status_q);
            W_TOPO:    rdata = TOPO;
            W_ADDR_LO: rdata = alo_q;
            W_ADDR_HI: rdata = ahi_q;
            W_SIZE:    rdata = size_q;
            W_MW_CNT:  rdata = 32'(NUM_MW);
            W_MW1_OFS: rdata = MW1_OFS;
            W_SP_OFS:  rdata = SP_OFS;
            W_SP_CNT:  rdata = 32'(SPAD_COUNT);
            W_DB_SZ:   rdata = 32'(DB_ENTRY_BYTES);
            default:   rdata = (widx >= W_DB_BASE && widx < DB_END) ? db_entry : 32'd0;
        endcase
    end
endmodule

// File: rtl/hbr_link_join.sv
// Module: joins the two hosts' binding requests.
// Emits one registered pulse on both host outputs when both requests first
// stand together. Assumes the requests are registered.
module hbr_link_join (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    output logic [1:0] evt
);
    logic both_q;

    // Edge-detect the joint request and pulse both hosts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            both_q <= 1'b0;
            evt    <= 2'b00;
        end else begin
            both_q <= &req;
            evt    <= {2{(&req) & ~both_q}};
        end
    end
endmodule

// File: rtl/dual_host_cmd_regs.sv
// Module: top of the dual-host bridge command register block.
// Instantiates one config region per host: host 0 is the upstream side,
// host 1 the downstream side. Also instantiates the link-up joiner.
// Assumes each host issues at most one access per cycle.
module dual_host_cmd_regs #(
    parameter int NUM_MW         = 4,
    parameter int DB_MAX         = 32,
    parameter int DB_ENTRY_BYTES = 4,
    parameter int SPAD_COUNT     = 8,
    parameter int AW             = 6,
    parameter int DBW            = $clog2(DB_MAX + 1)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [1:0]                          bus_wr,
    input  logic [1:0][AW-1:0]                  bus_addr,
    input  logic [1:0][31:0]                    bus_wdata,
    output logic [1:0][31:0]                    bus_rdata,
    output logic [1:0]                          link_up_evt,
    output logic [1:0][DBW-1:0]                 db_count,
    output logic [1:0]                          db_msix,
    output logic [1:0][NUM_MW-1:0]              mw_valid,
    output logic [1:0][NUM_MW-1:0][63:0]        mw_addr,
    output logic [1:0][NUM_MW-1:0][31:0]        mw_size
);
    logic [1:0] busy;
    logic [1:0] link_req;

    for (genvar h = 0; h < 2; h++) begin : g_host
        hbr_host_port #(
            .NUM_MW(NUM_MW), .DB_MAX(DB_MAX), .DB_ENTRY_BYTES(DB_ENTRY_BYTES),
            .SPAD_COUNT(SPAD_COUNT), .AW(AW), .DBW(DBW),
            .TOPO((h == 0) ? hbr_pkg::TOPO_UP : hbr_pkg::TOPO_DOWN)
        ) u_port (
            .clk(clk), .rst_n(rst_n),
            .wr(bus_wr[h]), .addr(bus_addr[h]), .wdata(bus_wdata[h]),
            .rdata(bus_rdata[h]), .busy(busy[h]), .link_req(link_req[h]),
            .db_count(db_count[h]), .db_msix(db_msix[h]),
            .mw_valid(mw_valid[h]), .mw_addr(mw_addr[h]), .mw_size(mw_size[h])
        );
    end

    hbr_link_join u_join (
        .clk(clk), .rst_n(rst_n), .req(link_req), .evt(link_up_evt)
    );
endmodule

// File: rtl/hbr_checker.sv
// Module: property checker bound to the register block top.
// Watches the command engine, the window settings and the link joiner.
module hbr_checker #(
    parameter int NUM_MW = 4,
    parameter int DB_MAX = 32,
    parameter int DBW    = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [1:0]                    busy,
    input logic [1:0]                    link_req,
    input logic [1:0]                    link_up_evt,
    input logic [1:0][DBW-1:0]           db_count,
    input logic [1:0][NUM_MW-1:0][63:0]  mw_addr
);
    // R2: a command runs for exactly one cycle.
    a_r2_exec_one_cycle_h0: assert property (@(posedge clk) disable iff (!rst_n)
        busy[0] |=> !busy[0]);
    a_r2_exec_one_cycle_h1: assert property (@(posedge clk) disable iff (!rst_n)
        busy[1] |=> !busy[1]);
    // R3: the stored doorbell count never exceeds the limit.
    a_r3_db_bound_h0: assert property (@(posedge clk) disable iff (!rst_n)
        32'(db_count[0]) <= 32'(DB_MAX));
    a_r3_db_bound_h1: assert property (@(posedge clk) disable iff (!rst_n)
        32'(db_count[1]) <= 32'(DB_MAX));
    // R4: window addresses change only as the result of a running command.
    a_r4_mw_hold_h0: assert property (@(posedge clk) disable iff (!rst_n)
        !busy[0] |=> $stable(mw_addr[0]));
    a_r4_mw_hold_h1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy[1] |=> $stable(mw_addr[1]));
    // R6: both hosts see the event together.
    a_r6_evt_paired: assert property (@(posedge clk) disable iff (!rst_n)
        link_up_evt[0] == link_up_evt[1]);
    // R6: the event lasts one cycle.
    a_r6_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        link_up_evt[0] |=> !link_up_evt[0]);
    // R6: the event follows a cycle in which both requests stood.
    a_r6_evt_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        link_up_evt[0] |-> $past(link_req[0] && link_req[1]));
endmodule

bind dual_host_cmd_regs hbr_checker #(
    .NUM_MW(NUM_MW), .DB_MAX(DB_MAX), .DBW(DBW)
) u_hbr_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .link_req(link_req),
    .link_up_evt(link_up_evt), .db_count(db_count), .mw_addr(mw_addr)
);

// File: tb/test_dual_host_cmd_regs.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module test_dual_host_cmd_regs;
    localparam int NMW = 4;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic [1:0]                 bus_wr = '0;
    logic [1:0][5:0]            bus_addr = '0;
    logic [1:0][31:0]           bus_wdata = '0;
    logic [1:0][31:0]           bus_rdata;
    logic [1:0]                 link_up_evt;
    logic [1:0][5:0]            db_count;
    logic [1:0]                 db_msix;
    logic [1:0][NMW-1:0]        mw_valid;
    logic [1:0][NMW-1:0][63:0]  mw_addr;
    logic [1:0][NMW-1:0][31:0]  mw_size;

    int n_cmp = 0;
    int n_bad = 0;
    int pulses = 0;
    bit done = 0;

    dual_host_cmd_regs i_dual_host_cmd_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .link_up_evt(link_up_evt),
        .db_count(db_count), .db_msix(db_msix), .mw_valid(mw_valid),
        .mw_addr(mw_addr), .mw_size(mw_size)
    );

    // 250 MHz: 4 time units per period, taken as ns.
    always #2 clk = ~clk;

    // Reference model state.
    logic [31:0] m_cmd [2], m_arg [2], m_alo [2], m_ahi [2], m_size [2];
    int          m_stat [2];
    bit          m_req [2];
    int          m_dbn [2];
    bit          m_msix [2];
    bit          m_mwv [2][NMW];
    logic [63:0] m_mwa [2][NMW];
    logic [31:0] m_mws [2][NMW];
    bit          m_both;
    bit          m_evt;

    function automatic logic [31:0] m_read(int h, int a);
        case (a)
            0: return m_cmd[h];
            1: return m_arg[h];
            2: return 32'(m_stat[h]);
            3: return (h == 0) ? 32'd1 : 32'd2;
            4: return m_alo[h];
            5: return m_ahi[h];
            6: return m_size[h];
            7: return 32'd4;
            8: return 32'd128;
            9: return 32'd176;
            10: return 32'd8;
            11: return 32'd4;
            default: begin
                if (a >= 12 && a < 44) return (a - 12 < m_dbn[h]) ? 32'(a - 11) : 32'd0;
                return 32'd0;
            end
        endcase
    endfunction

    // Advance the model on each clock edge from the driven inputs.
    always @(posedge clk) begin : model
        bit nb;
        if (!rst_n) begin
            m_both = 0; m_evt = 0;
            for (int h = 0; h < 2; h++) begin
                m_cmd[h] = 0; m_arg[h] = 0; m_alo[h] = 0; m_ahi[h] = 0; m_size[h] = 0;
                m_stat[h] = 0; m_req[h] = 0; m_dbn[h] = 0; m_msix[h] = 0;
                for (int w = 0; w < NMW; w++) begin
                    m_mwv[h][w] = 0; m_mwa[h][w] = 0; m_mws[h][w] = 0;
                end
            end
        end else begin
            nb = m_req[0] && m_req[1];
            m_evt = nb && !m_both;
            m_both = nb;
            for (int h = 0; h < 2; h++) begin
                if (m_cmd[h] != 0) begin
                    m_stat[h] = 2;
                    if (m_cmd[h] == 1 && m_arg[h][15:0] <= 32) begin
                        m_stat[h] = 1; m_dbn[h] = int'(m_arg[h][15:0]); m_msix[h] = m_arg[h][16];
                    end else if (m_cmd[h] == 2 && m_arg[h] < NMW) begin
                        m_stat[h] = 1;
                        m_mwv[h][m_arg[h]] = 1;
                        m_mwa[h][m_arg[h]] = {m_ahi[h], m_alo[h]};
                        m_mws[h][m_arg[h]] = m_size[h];
                    end else if (m_cmd[h] == 3) begin
                        m_stat[h] = 1; m_req[h] = m_arg[h][0];
                    end
                    m_cmd[h] = 0;
                end else if (bus_wr[h] && bus_addr[h] == 0 && bus_wdata[h] != 0) begin
                    m_cmd[h] = bus_wdata[h]; m_stat[h] = 0;
                end
                if (bus_wr[h]) begin
                    case (int'(bus_addr[h]))
                        1: m_arg[h] = bus_wdata[h];
                        4: m_alo[h] = bus_wdata[h];
                        5: m_ahi[h] = bus_wdata[h];
                        6: m_size[h] = bus_wdata[h];
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model just after each edge.
    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk("R6 link event", 64'(link_up_evt), m_evt ? 64'd3 : 64'd0);
            for (int h = 0; h < 2; h++) begin
                chk("R1 read data", 64'(bus_rdata[h]), 64'(m_read(h, int'(bus_addr[h]))));
                chk("R3 doorbell count", 64'(db_count[h]), 64'(m_dbn[h]));
                chk("R3 msix select", 64'(db_msix[h]), 64'(m_msix[h]));
                for (int w = 0; w < NMW; w++) begin
                    chk("R4 window valid", 64'(mw_valid[h][w]), 64'(m_mwv[h][w]));
                    chk("R4 window address", mw_addr[h][w], m_mwa[h][w]);
                    chk("R4 window size", 64'(mw_size[h][w]), 64'(m_mws[h][w]));
                end
            end
            if (link_up_evt[0]) pulses++;
        end
    end

    task automatic wr(int h, int a, logic [31:0] d);
        @(negedge clk);
        bus_wr[h] = 1'b1; bus_addr[h] = 6'(a); bus_wdata[h] = d;
        @(negedge clk);
        bus_wr[h] = 1'b0;
    endtask

    task automatic rd(int h, int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr[h] = 6'(a);
        @(posedge clk);
        #1 d = bus_rdata[h];
    endtask

    task automatic run_cmd(int h, logic [31:0] op, logic [31:0] arg);
        wr(h, 1, arg);
        wr(h, 0, op);
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin : stim
        logic [31:0] v;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state.
        rd(0, 2, v); chk("R9 status after reset", 64'(v), 0);
        rd(1, 1, v); chk("R9 argument after reset", 64'(v), 0);
        chk("R9 windows after reset", 64'(mw_valid), 0);
        chk("R9 event after reset", 64'(link_up_evt), 0);

        // R1: descriptor words.
        rd(0, 3, v); chk("R1 topology host0", 64'(v), 1);
        rd(1, 3, v); chk("R1 topology host1", 64'(v), 2);
        rd(0, 7, v); chk("R1 window count", 64'(v), 4);
        rd(1, 8, v); chk("R1 window-1 offset", 64'(v), 128);
        rd(0, 9, v); chk("R1 scratchpad offset", 64'(v), 176);
        rd(1, 10, v); chk("R1 scratchpad count", 64'(v), 8);
        rd(0, 11, v); chk("R1 doorbell slot size", 64'(v), 4);
        rd(0, 50, v); chk("R1 unmapped word", 64'(v), 0);
        wr(0, 6, 32'hCAFE_0001);
        rd(0, 6, v); chk("R1 size readback", 64'(v), 64'h0000_0000_CAFE_0001);

        // R8: read-only words and zero command are ignored.
        wr(0, 2, 32'h7); rd(0, 2, v); chk("R8 status write ignored", 64'(v), 0);
        wr(0, 3, 32'h9); rd(0, 3, v); chk("R8 topology write ignored", 64'(v), 1);
        wr(0, 12, 32'h5); rd(0, 12, v); chk("R8 doorbell data write ignored", 64'(v), 0);
        wr(0, 0, 32'h0); rd(0, 0, v); chk("R8 zero command ignored", 64'(v), 0);
        rd(0, 2, v); chk("R8 status after zero command", 64'(v), 0);

        // R3, R2: doorbell configure with MSI-X.
        run_cmd(0, 32'd1, 32'h0001_0005);
        rd(0, 2, v); chk("R2 status success", 64'(v), 1);
        rd(0, 0, v); chk("R2 command cleared", 64'(v), 0);
        chk("R3 count 5", 64'(db_count[0]), 5);
        chk("R3 msix set", 64'(db_msix[0]), 1);
        rd(0, 12, v); chk("R3 first doorbell data", 64'(v), 1);
        rd(0, 16, v); chk("R3 last doorbell data", 64'(v), 5);
        rd(0, 17, v); chk("R3 past count data", 64'(v), 0);
        run_cmd(0, 32'd1, 32'd32);
        rd(0, 2, v); chk("R3 count 32 accepted", 64'(v), 1);
        rd(0, 43, v); chk("R3 doorbell data 31", 64'(v), 32);
        chk("R3 msix cleared", 64'(db_msix[0]), 0);

        // R5: doorbell count above limit.
        run_cmd(0, 32'd1, 32'd33);
        rd(0, 2, v); chk("R5 count 33 rejected", 64'(v), 2);
        chk("R5 count kept", 64'(db_count[0]), 32);

        // R4: window configure on host 1 at the top index.
        wr(1, 4, 32'h1000_0000); wr(1, 5, 32'h0000_00AB); wr(1, 6, 32'h0001_0000);
        run_cmd(1, 32'd2, 32'd3);
        rd(1, 2, v); chk("R4 window 3 success", 64'(v), 1);
        chk("R4 window 3 address", mw_addr[1][3], 64'h0000_00AB_1000_0000);
        chk("R4 window 3 size", 64'(mw_size[1][3]), 64'h1_0000);
        chk("R10 host0 windows untouched", 64'(mw_valid[0]), 0);
        wr(1, 4, 32'h2222_0000);
        run_cmd(1, 32'd2, 32'd0);
        chk("R4 window 0 valid", 64'(mw_valid[1]), 64'b1001);

        // R5: bad index and unknown opcode.
        wr(1, 4, 32'h3333_0000);
        run_cmd(1, 32'd2, 32'd4);
        rd(1, 2, v); chk("R5 index 4 rejected", 64'(v), 2);
        chk("R5 window 0 kept", mw_addr[1][0], 64'h0000_00AB_2222_0000);
        run_cmd(1, 32'd7, 32'd0);
        rd(1, 2, v); chk("R5 unknown opcode", 64'(v), 2);
        rd(0, 2, v); chk("R10 host0 status untouched", 64'(v), 2);

        // R6: link join.
        p0 = pulses;
        run_cmd(0, 32'd3, 32'd1);
        repeat (3) @(negedge clk);
        chk("R6 no event with one request", 64'(pulses - p0), 0);
        run_cmd(1, 32'd3, 32'd1);
        repeat (3) @(negedge clk);
        chk("R6 one event after both", 64'(pulses - p0), 1);

        // R7: repeated request does not re-pulse; withdraw re-arms.
        run_cmd(0, 32'd3, 32'd1);
        repeat (3) @(negedge clk);
        chk("R7 no event on repeat", 64'(pulses - p0), 1);
        run_cmd(1, 32'd3, 32'd0);
        repeat (3) @(negedge clk);
        chk("R7 no event on withdraw", 64'(pulses - p0), 1);
        run_cmd(1, 32'd3, 32'd1);
        repeat (3) @(negedge clk);
        chk("R7 event after re-arm", 64'(pulses - p0), 2);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule